// File: doc/BRIEF.md
# Microcoded Single-Bus Processor Core

This block is a compact processor core in which every transfer between its storage elements crosses one shared 32-bit bus that carries addresses and data alike. A microprogram sequencer reads a small control store one word per clock. Each word says which single source drives the bus and which registers capture from it. The four sources are the program counter, the memory read data, the accumulator and the ALU output. The datapath holds a program counter, an instruction register, a three-bit flag register, an accumulator, a 32-entry register file with two read ports and one write port, and a 16-function ALU whose two inputs each pass through a selector.

An instruction starts with a two-cycle memory read that keeps the program counter on the bus. The memory then drives the fetched word into the instruction register. The program counter is advanced through the ALU and the accumulator, and one decode step jumps to the routine for the opcode. The central operation shifts a register left by an immediate count and writes the result back. A register-register ALU form and an add-immediate form share the same machinery. A step counter shows how far the current instruction has progressed. The memory is outside the block: it latches the bus as an address while the read strobe is high and returns the word on `mem_rdata`.

Top module: `mcpu_core`

## Requirements
- R1: After the asynchronous active-low reset releases, the step counter and all three flags are 0, and the first cycle is a fetch: the program counter drives 0 onto the bus and the read strobe is high.
- R2: `bus_drv` has at most one bit set in any cycle. The bits are 0 program counter, 1 memory, 2 accumulator and 3 ALU. `bus_val` is 0 when no bit is set.
- R3: Each fetch keeps the read strobe high for exactly steps 0 and 1, with the program counter stable on the bus. In step 2 memory drives the bus and `ir_load` is high. `mem_wr` never rises.
- R4: In step 3 the program counter drives the bus. In step 4 the accumulator drives the old value plus 4, which becomes the new program counter.
- R5: Step 5 is a decode step with no bus driver. The opcode sits in instruction bits 31:28. Opcode 0 and any opcode above 3 return to fetch, so such an instruction takes 6 cycles.
- R6: Opcode 1 (shift left by immediate) shifts register `rd` (bits 23:19) left by the low five bits of the immediate (bits 8:0). It computes in step 6 with no bus driver. In step 7 the accumulator drives the result while `reg_load` writes it to `rd`. The instruction takes 8 cycles.
- R7: The flags are bit 0 zero, bit 1 carry and bit 2 sign (result bit 31). For shifts, carry is the last bit shifted out, or 0 for a count of 0. ADD gives the carry out. SUB gives the unsigned borrow. Every other operation clears carry.
- R8: Flags change only at the end of the execute step of opcodes 1, 2 and 3. The new value is visible from the following cycle, and all other steps and instructions leave the flags unchanged.
- R9: Opcode 2 computes `ra` (bits 18:14) against `rb` (bits 13:9) with the operation in bits 27:24 and writes `rd` in step 7. The codes are 0 pass A, 1 add, 2 subtract, 3 and, 4 or, 5 xor, 6 shift left, 7 logical shift right, 8 arithmetic shift right, 9 nor, 10 xnor, 11 A and not B, 12 pass B, 13 negate A, 14 rotate left and 15 rotate right. Shift counts are B's low five bits.
- R10: Opcode 3 adds the zero-extended 9-bit immediate to `ra`. The ALU drives the sum on the bus in step 6 while `rd` is written, so the instruction takes 7 cycles.
- R11: `phase` counts the steps of the current instruction from 0 and returns to 0 on the first fetch step of the next instruction.
- R12: Reset clears all 32 registers. A register is written only from the bus value in a cycle with `reg_load` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 32 | Word returned by memory, placed on the bus when the memory drive bit is set |
| bus_val | output | 32 | Current value of the shared bus |
| bus_drv | output | 4 | Bus drive enables: PC, memory, accumulator, ALU |
| mem_rd | output | 1 | Memory read strobe; bus holds the address |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register captures the bus this cycle |
| reg_load | output | 1 | Register `rd` captures the bus this cycle |
| phase | output | 4 | Step number within the current instruction |
| flags | output | 3 | Sign, carry, zero |

## Verification
Every bus control output is combinational from the sequencer state, so a step's value is due in the same cycle the step number shows. The flags are registered and appear one cycle after the execute step. The bench expands each fetched instruction into a list of per-cycle expected records: 6, 7 or 8 records depending on the opcode. It takes one record per clock, starting in the cycle reset releases, and compares it at the falling edge. A record that lands in the wrong cycle therefore shows up as a mismatch on the bus value, the driver code or the step number.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

  localparam int DATA_W = 32;
  localparam int REG_N  = 32;
  localparam int REG_AW = $clog2(REG_N);
  localparam int UPC_W  = 4;
  localparam int OPC_W  = 4;
  localparam int IMM_W  = 9;
  localparam int SH_W   = $clog2(DATA_W);
  localparam int DRV_N  = 4;

  // bus source bit positions
  localparam int DRV_PC  = 0;
  localparam int DRV_MEM = 1;
  localparam int DRV_ACC = 2;
  localparam int DRV_ALU = 3;

  typedef enum logic [3:0] {
    ALU_PASSX = 4'd0,  ALU_ADD  = 4'd1,  ALU_SUB   = 4'd2,  ALU_AND  = 4'd3,
    ALU_OR    = 4'd4,  ALU_XOR  = 4'd5,  ALU_SHL   = 4'd6,  ALU_SHR  = 4'd7,
    ALU_SAR   = 4'd8,  ALU_NOR  = 4'd9,  ALU_XNOR  = 4'd10, ALU_ANDN = 4'd11,
    ALU_PASSY = 4'd12, ALU_NEGX = 4'd13, ALU_ROL   = 4'd14, ALU_ROR  = 4'd15
  } alu_op_e;

  typedef enum logic       {XS_REGA, XS_BUS} xsel_e;
  typedef enum logic [1:0] {YS_REGB, YS_IMM, YS_FOUR, YS_BUS} ysel_e;
  typedef enum logic       {AS_RD, AS_RA} asel_e;

  // control store addresses
  localparam logic [UPC_W-1:0] UA_F0   = 4'd0;
  localparam logic [UPC_W-1:0] UA_F1   = 4'd1;
  localparam logic [UPC_W-1:0] UA_F2   = 4'd2;
  localparam logic [UPC_W-1:0] UA_INC  = 4'd3;
  localparam logic [UPC_W-1:0] UA_PCW  = 4'd4;
  localparam logic [UPC_W-1:0] UA_DEC  = 4'd5;
  localparam logic [UPC_W-1:0] UA_SHL  = 4'd6;
  localparam logic [UPC_W-1:0] UA_WB   = 4'd7;
  localparam logic [UPC_W-1:0] UA_ALUR = 4'd8;
  localparam logic [UPC_W-1:0] UA_ADDI = 4'd9;

  // opcodes decoded by the dispatch step
  localparam logic [OPC_W-1:0] OPC_SHLI = 4'd1;
  localparam logic [OPC_W-1:0] OPC_ALUR = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADDI = 4'd3;

  typedef struct packed {
    logic             drv_pc;
    logic             drv_mem;
    logic             drv_acc;
    logic             drv_alu;
    logic             ld_ir;
    logic             ld_pc;
    logic             ld_acc;
    logic             ld_reg;
    logic             ld_flg;
    logic             mem_rd;
    logic             mem_wr;
    xsel_e            xsel;
    ysel_e            ysel;
    asel_e            asel;
    logic             op_ir;
    alu_op_e          alu_op;
    logic             dispatch;
    logic [UPC_W-1:0] next;
  } uinstr_t;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              carry;
  } alu_out_t;

  function automatic alu_out_t alu_eval(alu_op_e op, logic [DATA_W-1:0] x,
                                        logic [DATA_W-1:0] y);
    alu_out_t        o;
    logic [SH_W-1:0] sh;
    logic [DATA_W:0] wide;
    sh   = y[SH_W-1:0];
    o    = '0;
    wide = '0;
    unique case (op)
      ALU_PASSX: o.res = x;
      ALU_ADD:   begin wide = {1'b0, x} + {1'b0, y}; o.res = wide[DATA_W-1:0]; o.carry = wide[DATA_W]; end
      ALU_SUB:   begin wide = {1'b0, x} - {1'b0, y}; o.res = wide[DATA_W-1:0]; o.carry = wide[DATA_W]; end
      ALU_AND:   o.res = x & y;
      ALU_OR:    o.res = x | y;
      ALU_XOR:   o.res = x ^ y;
      ALU_SHL:   begin wide = {1'b0, x} << sh; o.res = wide[DATA_W-1:0]; o.carry = wide[DATA_W]; end
      ALU_SHR:   begin wide = {x, 1'b0} >> sh; o.res = wide[DATA_W:1]; o.carry = wide[0]; end
      ALU_SAR:   begin wide = $signed({x, 1'b0}) >>> sh; o.res = wide[DATA_W:1]; o.carry = wide[0]; end
      ALU_NOR:   o.res = ~(x | y);
      ALU_XNOR:  o.res = ~(x ^ y);
      ALU_ANDN:  o.res = x & ~y;
      ALU_PASSY: o.res = y;
      ALU_NEGX:  o.res = '0 - x;
      ALU_ROL:   o.res = (x << sh) | (x >> (DATA_W - int'(sh)));
      ALU_ROR:   o.res = (x >> sh) | (x << (DATA_W - int'(sh)));
      default:   o.res = x;
    endcase
    return o;
  endfunction

  function automatic uinstr_t ucode_word(logic [UPC_W-1:0] a);
    uinstr_t w;
    w = '0;
    unique case (a)
      UA_F0:   begin w.drv_pc = 1'b1; w.mem_rd = 1'b1; w.next = UA_F1; end
      UA_F1:   begin w.drv_pc = 1'b1; w.mem_rd = 1'b1; w.next = UA_F2; end
      UA_F2:   begin w.drv_mem = 1'b1; w.ld_ir = 1'b1; w.next = UA_INC; end
      UA_INC:  begin
        w.drv_pc = 1'b1; w.xsel = XS_BUS; w.ysel = YS_FOUR;
        w.alu_op = ALU_ADD; w.ld_acc = 1'b1; w.next = UA_PCW;
      end
      UA_PCW:  begin w.drv_acc = 1'b1; w.ld_pc = 1'b1; w.next = UA_DEC; end
      UA_DEC:  begin w.dispatch = 1'b1; w.next = UA_F0; end
      UA_SHL:  begin
        w.asel = AS_RD; w.xsel = XS_REGA; w.ysel = YS_IMM; w.alu_op = ALU_SHL;
        w.ld_acc = 1'b1; w.ld_flg = 1'b1; w.next = UA_WB;
      end
      UA_WB:   begin w.drv_acc = 1'b1; w.ld_reg = 1'b1; w.next = UA_F0; end
      UA_ALUR: begin
        w.asel = AS_RA; w.xsel = XS_REGA; w.ysel = YS_REGB; w.op_ir = 1'b1;
        w.ld_acc = 1'b1; w.ld_flg = 1'b1; w.next = UA_WB;
      end
      UA_ADDI: begin
        w.asel = AS_RA; w.xsel = XS_REGA; w.ysel = YS_IMM; w.alu_op = ALU_ADD;
        w.drv_alu = 1'b1; w.ld_reg = 1'b1; w.ld_flg = 1'b1; w.next = UA_F0;
      end
      default: w.next = UA_F0;
    endcase
    return w;
  endfunction

  function automatic logic [UPC_W-1:0] dispatch_target(logic [OPC_W-1:0] opc);
    unique case (opc)
      OPC_SHLI: return UA_SHL;
      OPC_ALUR: return UA_ALUR;
      OPC_ADDI: return UA_ADDI;
      default:  return UA_F0;
    endcase
  endfunction

endpackage

// File: rtl/mcpu_useq.sv
module mcpu_useq
  import mcpu_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output uinstr_t          uw,
  output logic [UPC_W-1:0] upc,
  output logic [PH_W-1:0]  phase,
  output logic             ph_clr
);

  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_nxt;
  logic [PH_W-1:0]  phase_q;

  assign uw      = ucode_word(upc_q);
  assign upc_nxt = uw.dispatch ? dispatch_target(opcode) : uw.next;
  // the step that hands control back to fetch also clears the step counter
  assign ph_clr  = (upc_nxt == UA_F0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q   <= UA_F0;
      phase_q <= '0;
    end else begin
      upc_q   <= upc_nxt;
      phase_q <= ph_clr ? '0 : phase_q + 1'b1;
    end
  end

  assign upc   = upc_q;
  assign phase = phase_q;

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
  parameter int N  = 32,
  parameter int W  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] cells [N];

  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cells[i] <= '0;
      else if (we && (waddr == AW'(i)))  cells[i] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
  import mcpu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              zero,
  output logic              sign
);

  alu_out_t o;

  assign o     = alu_eval(op, x, y);
  assign res   = o.res;
  assign carry = o.carry;
  assign zero  = (o.res == '0);
  assign sign  = o.res[DATA_W-1];

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
  import mcpu_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] bus_val,
  output logic [DRV_N-1:0]  bus_drv,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              ir_load,
  output logic              reg_load,
  output logic [PH_W-1:0]   phase,
  output logic [2:0]        flags
);

  uinstr_t           uw;
  logic [UPC_W-1:0]  upc;
  logic              ph_clr;
  logic              flag_ld;

  logic [DATA_W-1:0] ir_q, pc_q, acc_q;
  logic [2:0]        flags_q;

  // instruction fields
  logic [OPC_W-1:0]  f_opc;
  logic [3:0]        f_op;
  logic [REG_AW-1:0] f_rd, f_ra, f_rb;
  logic [IMM_W-1:0]  f_imm;

  assign f_opc = ir_q[31:28];
  assign f_op  = ir_q[27:24];
  assign f_rd  = ir_q[23:19];
  assign f_ra  = ir_q[18:14];
  assign f_rb  = ir_q[13:9];
  assign f_imm = ir_q[IMM_W-1:0];

  mcpu_useq #(.PH_W(PH_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (f_opc),
    .uw     (uw),
    .upc    (upc),
    .phase  (phase),
    .ph_clr (ph_clr)
  );

  // register file
  logic [REG_AW-1:0] a_addr;
  logic [DATA_W-1:0] rd_a, rd_b;

  assign a_addr = (uw.asel == AS_RA) ? f_ra : f_rd;

  mcpu_regfile #(.N(REG_N), .W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (uw.ld_reg),
    .waddr   (f_rd),
    .wdata   (bus_val),
    .raddr_a (a_addr),
    .raddr_b (f_rb),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  // bus sources other than the ALU; the ALU selectors tap this net
  logic [DATA_W-1:0] bus_core;
  assign bus_core = ({DATA_W{uw.drv_pc}}  & pc_q)
                  | ({DATA_W{uw.drv_mem}} & mem_rdata)
                  | ({DATA_W{uw.drv_acc}} & acc_q);

  // ALU input selectors
  logic [DATA_W-1:0] alu_x, alu_y, alu_res;
  logic              alu_c, alu_z, alu_s;
  alu_op_e           op_sel;

  always_comb begin
    alu_x = (uw.xsel == XS_BUS) ? bus_core : rd_a;
    unique case (uw.ysel)
      YS_REGB: alu_y = rd_b;
      YS_IMM:  alu_y = DATA_W'(f_imm);
      YS_FOUR: alu_y = DATA_W'(4);
      YS_BUS:  alu_y = bus_core;
      default: alu_y = rd_b;
    endcase
  end

  assign op_sel = uw.op_ir ? alu_op_e'(f_op) : uw.alu_op;

  mcpu_alu u_alu (
    .op    (op_sel),
    .x     (alu_x),
    .y     (alu_y),
    .res   (alu_res),
    .carry (alu_c),
    .zero  (alu_z),
    .sign  (alu_s)
  );

  assign bus_val = bus_core | ({DATA_W{uw.drv_alu}} & alu_res);
  assign bus_drv[DRV_PC]  = uw.drv_pc;
  assign bus_drv[DRV_MEM] = uw.drv_mem;
  assign bus_drv[DRV_ACC] = uw.drv_acc;
  assign bus_drv[DRV_ALU] = uw.drv_alu;

  assign flag_ld = uw.ld_flg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q    <= '0;
      pc_q    <= '0;
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      if (uw.ld_ir)  ir_q    <= bus_val;
      if (uw.ld_pc)  pc_q    <= bus_val;
      if (uw.ld_acc) acc_q   <= alu_res;
      if (flag_ld)   flags_q <= {alu_s, alu_c, alu_z};
    end
  end

  assign mem_rd   = uw.mem_rd;
  assign mem_wr   = uw.mem_wr;
  assign ir_load  = uw.ld_ir;
  assign reg_load = uw.ld_reg;
  assign flags    = flags_q;

endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk
  import mcpu_pkg::*;
#(
  parameter int PH_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_val,
  input logic [DRV_N-1:0]  bus_drv,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              ir_load,
  input logic              reg_load,
  input logic [2:0]        flags,
  input logic              flag_ld,
  input logic [UPC_W-1:0]  upc,
  input logic [PH_W-1:0]   phase,
  input logic              ph_clr
);

  // R2
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_drv));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> (mem_rd && $stable(bus_val)));

  // R3
  rd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |-> $past(mem_rd, 2));

  // R3
  ir_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> (bus_drv == 4'b0010));

  // R3
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_ld |=> $stable(flags));

  // R11
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UA_F0) |-> (phase == '0));

  // R11
  step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_clr |=> (phase == '0));

  // R12
  reg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_load |-> (bus_drv == 4'b0100 || bus_drv == 4'b1000));

endmodule

bind mcpu_core mcpu_core_chk #(.PH_W(PH_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_val  (bus_val),
  .bus_drv  (bus_drv),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .ir_load  (ir_load),
  .reg_load (reg_load),
  .flags    (flags),
  .flag_ld  (flag_ld),
  .upc      (upc),
  .phase    (phase),
  .ph_clr   (ph_clr)
);

// File: tb/mcpu_core_bench.sv
module mcpu_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata;
  logic [31:0] bus_val;
  logic [3:0]  bus_drv;
  logic        mem_rd, mem_wr, ir_load, reg_load;
  logic [3:0]  phase;
  logic [2:0]  flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcpu_core u_mcpu_core (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .bus_val(bus_val),
    .bus_drv(bus_drv), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
    .reg_load(reg_load), .phase(phase), .flags(flags)
  );

  // memory model: address latched from the bus while the read strobe is high
  logic [31:0] mem [MEM_WORDS];
  logic [5:0]  addr_q = '0;
  always @(posedge clk) if (mem_rd) addr_q <= bus_val[7:2];
  assign mem_rdata = mem[addr_q];

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] bus;
    logic [3:0]  drv;
    logic        rd;
    logic        irl;
    logic        rl;
    int          ph;
    logic [2:0]  flg;
    string       tag;
    string       ftag;
  } exp_t;

  exp_t exp_q[$];

  // reference state
  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [2:0]  m_flags;
  bit          first_rec;

  function automatic logic [31:0] enc(int opc, int op, int rd, int ra, int rb, int imm);
    return (32'(opc) << 28) | (32'(op) << 24) | (32'(rd) << 19) |
           (32'(ra) << 14) | (32'(rb) << 9) | 32'(imm & 511);
  endfunction

  function automatic logic [32:0] ref_alu(int op, logic [31:0] x, logic [31:0] y);
    logic [31:0] v;
    logic        c;
    longint      s;
    int          n;
    n = int'(y[4:0]);
    v = x;
    c = 1'b0;
    case (op)
      0:  v = x;
      1:  begin s = longint'(x) + longint'(y); v = s[31:0]; c = s[32]; end
      2:  begin v = x - y; c = (x < y); end
      3:  v = x & y;
      4:  v = x | y;
      5:  v = x ^ y;
      6:  for (int i = 0; i < n; i++) begin c = v[31]; v = {v[30:0], 1'b0}; end
      7:  for (int i = 0; i < n; i++) begin c = v[0]; v = {1'b0, v[31:1]}; end
      8:  for (int i = 0; i < n; i++) begin c = v[0]; v = {v[31], v[31:1]}; end
      9:  v = ~(x | y);
      10: v = ~(x ^ y);
      11: v = x & ~y;
      12: v = y;
      13: v = 32'd0 - x;
      14: for (int i = 0; i < n; i++) v = {v[30:0], v[31]};
      default: for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
    endcase
    return {c, v};
  endfunction

  task automatic push(logic [31:0] b, logic [3:0] d, logic rd, logic irl, logic rl,
                      int ph, string tag, string ftag);
    exp_t e;
    e.bus = b; e.drv = d; e.rd = rd; e.irl = irl; e.rl = rl; e.ph = ph;
    e.flg = m_flags; e.ftag = ftag;
    e.tag = first_rec ? "R1" : tag;
    first_rec = 0;
    exp_q.push_back(e);
  endtask

  task automatic model_reset();
    m_pc = '0;
    m_flags = '0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    first_rec = 1;
    exp_q.delete();
  endtask

  task automatic model_instr();
    logic [31:0] w, x, y, r;
    logic [32:0] cr;
    int opc, op, rd, ra, rb;
    string ft, xt;
    w   = mem[m_pc[7:2]];
    opc = int'(w[31:28]); op = int'(w[27:24]);
    rd  = int'(w[23:19]); ra = int'(w[18:14]); rb = int'(w[13:9]);
    y   = {23'd0, w[8:0]};
    ft  = (opc >= 1 && opc <= 3) ? "R7" : "R8";
    push(m_pc, 4'b0001, 1, 0, 0, 0, "R3", ft);
    push(m_pc, 4'b0001, 1, 0, 0, 1, "R3", ft);
    push(w,    4'b0010, 0, 1, 0, 2, "R3", ft);
    push(m_pc, 4'b0001, 0, 0, 0, 3, "R4", ft);
    m_pc = m_pc + 4;
    push(m_pc, 4'b0100, 0, 0, 0, 4, "R4", ft);
    push('0,   4'b0000, 0, 0, 0, 5, "R5", ft);
    case (opc)
      1: begin
        cr = ref_alu(6, m_reg[rd], y); r = cr[31:0];
        push('0, 4'b0000, 0, 0, 0, 6, "R6", ft);
        m_flags = {r[31], cr[32], (r == 0)};
        push(r, 4'b0100, 0, 0, 1, 7, "R6", ft);
        m_reg[rd] = r;
      end
      2: begin
        x = m_reg[ra];
        cr = ref_alu(op, x, m_reg[rb]); r = cr[31:0];
        xt = (ra == 0) ? "R12" : "R9";
        push('0, 4'b0000, 0, 0, 0, 6, "R9", ft);
        m_flags = {r[31], cr[32], (r == 0)};
        push(r, 4'b0100, 0, 0, 1, 7, xt, ft);
        m_reg[rd] = r;
      end
      3: begin
        cr = ref_alu(1, m_reg[ra], y); r = cr[31:0];
        push(r, 4'b1000, 0, 0, 1, 6, "R10", ft);
        m_flags = {r[31], cr[32], (r == 0)};
        m_reg[rd] = r;
      end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // compare one expected record per clock, at the falling edge
  task automatic drain();
    exp_t e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(e.tag,  "bus_val",  bus_val,  e.bus);
      chk("R2",   "bus_drv",  {28'd0, bus_drv}, {28'd0, e.drv});
      chk(e.tag,  "mem_rd",   {31'd0, mem_rd},   {31'd0, e.rd});
      chk("R3",   "mem_wr",   {31'd0, mem_wr},   32'd0);
      chk(e.tag,  "ir_load",  {31'd0, ir_load},  {31'd0, e.irl});
      chk(e.tag,  "reg_load", {31'd0, reg_load}, {31'd0, e.rl});
      chk("R11",  "phase",    {28'd0, phase},    32'(e.ph));
      chk(e.ftag, "flags",    {29'd0, flags},    {29'd0, e.flg});
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) model_instr();
    drain();
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    mem[0]  = enc(2, 9, 1, 0, 0, 0);        // r1 = r0 nor r0
    mem[1]  = enc(1, 0, 1, 0, 0, 5);        // shift r1 left 5
    mem[2]  = enc(3, 0, 2, 0, 0, 5);        // r2 = r0 + 5
    mem[3]  = enc(1, 0, 2, 0, 0, 5);        // shift r2 left 5
    mem[4]  = enc(1, 0, 3, 0, 0, 5);        // shift zero register: zero flag
    mem[5]  = enc(0, 0, 0, 0, 0, 0);        // no operation
    mem[6]  = enc(14, 0, 0, 0, 0, 0);       // unknown opcode
    mem[7]  = enc(2, 1, 4, 1, 1, 0);        // add with carry out
    mem[8]  = enc(2, 2, 5, 2, 1, 0);        // subtract with borrow
    mem[9]  = enc(3, 0, 6, 0, 0, 31);       // r6 = 31
    mem[10] = enc(2, 7, 7, 1, 6, 0);        // logical right by 31
    mem[11] = enc(1, 0, 2, 0, 0, 0);        // shift by zero
    mem[12] = enc(1, 0, 1, 0, 0, 9'h1E3);   // count from low five bits (3)
    mem[13] = enc(2, 8, 8, 4, 6, 0);        // arithmetic right
    mem[14] = enc(2, 14, 9, 1, 2, 0);       // rotate left
    mem[15] = enc(3, 0, 10, 2, 0, 9'h1FF);  // add immediate 511
    mem[16] = enc(1, 0, 10, 0, 0, 31);      // shift left 31
    mem[17] = enc(2, 13, 11, 2, 0, 0);      // negate
    mem[18] = enc(3, 0, 0, 0, 0, 7);        // write r0
    mem[19] = enc(2, 1, 12, 0, 0, 0);       // r12 = r0 + r0

    do_reset();
    run(20);
    // second reset: registers and flags must be cleared again
    do_reset();
    run(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule